// File: doc/BRIEF.md
# Iterative Fixed-Point Logarithm Unit (log2 / log10 / ln)

This block computes the base-2, base-10 or natural logarithm of a positive unsigned fixed-point operand with INT_W integer and FRAC_W fractional bits. The result is signed two's complement with the same split, and NBITS = INT_W + FRAC_W. On acceptance the operand's leading one is located. That position gives the integer part of log2, and the operand is shifted so that its mantissa lies in [1,2). The fractional bits of log2 are then produced one per clock, most significant first. Each step squares the mantissa; when the square reaches 2 the bit is 1 and the square is halved. For base 10 and base e, one extra cycle multiplies the binary result by a stored constant.

Operands enter on a valid/ready stream and results leave on another. A transfer happens on a rising edge where valid and ready are both high. The unit takes one operand at a time, and `in_ready` stays low from acceptance until the result has been taken. A result is held with `out_valid` high and `out_data`/`out_err` frozen for as long as `out_ready` is low. A zero operand, or the operation code reserved for square root, is not computed. It returns an error flag with the most negative value.

Top module: `log_unit`

## Requirements
- R1: After reset, `in_ready`=1 and `out_valid`, `done` and `out_err` are 0.
- R2: An operand is taken when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is low from then until the result is taken, and `in_valid` has no effect while it is low.
- R3: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and `out_data` and `out_err` do not change. After an edge with `out_valid` and `out_ready` both high, `out_valid` is 0 and `in_ready` is 1.
- R4: With code 01 (log2), the integer part of the result is the bit index of the operand's leading one minus FRAC_W, in two's complement. For a power of two the result is exact, e.g. operand 0x0080 (0.5) gives 0xFF00.
- R5: The log2 fraction is built MSB first. The mantissa is held with FRAC_W+1 fractional bits, and bits below that are dropped on alignment. Each step squares it and truncates the square to FRAC_W+1 fractional bits. If the square is at least 2, the bit is 1 and the mantissa becomes the square shifted right by one; otherwise the bit is 0 and the mantissa becomes the square.
- R6: With code 10 (log10), the result is floor(L·K10 / 2^NBITS). Here L is the signed log2 result and K10 = floor(2^NBITS / log2(10)).
- R7: With code 11 (ln), the result is floor(L·KE / 2^NBITS), where KE = floor(2^NBITS · ln 2).
- R8: A zero operand with code 01, 10 or 11 returns `out_err`=1 and `out_data` = the most negative value (0x8000 at defaults).
- R9: Code 00 (reserved for square root) returns `out_err`=1 and the most negative value for any operand.
- R10: `out_valid` first rises FRAC_W rising edges after the accepting edge for log2, and FRAC_W+1 edges after it for log10 and ln. For the error cases of R8 and R9 it rises at the accepting edge itself.
- R11: `done` is high for exactly one cycle: the first cycle of each result's `out_valid`.
- R12: `out_err` is 0 for every result computed from a nonzero operand with code 01, 10 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Unit can take an operand |
| in_op | input | 2 | 00 reserved, 01 log2, 10 log10, 11 ln |
| in_data | input | NBITS | Unsigned operand, FRAC_W fractional bits |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | NBITS | Signed result, FRAC_W fractional bits |
| out_err | output | 1 | Operand was zero or code was reserved |
| done | output | 1 | One-cycle pulse when a result first appears |

## Verification
The hardest case to reach is a non-power-of-two operand whose leading one sits above the mantissa width. There the truncation on alignment and on every squaring step decides each fraction bit. The stimulus uses operands such as 3.0, 1.5 and 3/256, which share one mantissa but have very different leading-one positions. For these, every iteration has been worked out by hand, and the same mantissa is also followed through both scale constants, including a negative log2 result where the floor rounds away from zero. A second hard case is an input offered while a computation is in flight. The bench drives a zero operand with `in_valid` high during the iterations and checks that the pending result is unchanged.

// File: rtl/log_pkg.sv
package log_pkg;

  typedef enum logic [1:0] {
    OP_ROOT  = 2'b00,
    OP_LOG2  = 2'b01,
    OP_LOG10 = 2'b10,
    OP_LN    = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ITER,
    ST_SCALE,
    ST_HOLD
  } state_e;

  localparam real INV_LOG2_10 = 0.30102999566398120;
  localparam real INV_LOG2_E  = 0.69314718055994531;

endpackage

// File: rtl/lead_one_find.sv
module lead_one_find #(
  parameter int W  = 16,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = PW'(i);
    end
  end
endmodule

// File: rtl/mant_align.sv
module mant_align #(
  parameter int W  = 16,
  parameter int MF = 9,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  input  logic [PW-1:0] pos,
  output logic [MF:0]   mant
);
  localparam int WW = W + MF;
  logic [WW-1:0] wide;

  always_comb begin
    wide = {vec, {MF{1'b0}}};
    mant = (MF+1)'(wide >> pos);
  end
endmodule

// File: rtl/sq_step.sv
module sq_step #(
  parameter int MF = 9
) (
  input  logic [MF:0] y_in,
  output logic        bit_out,
  output logic [MF:0] y_out
);
  localparam int SW = 2*MF + 2;
  logic [SW-1:0] sq;
  logic [MF+1:0] s;

  always_comb begin
    sq      = SW'(y_in) * SW'(y_in);
    s       = (MF+2)'(sq >> MF);
    bit_out = s[MF+1];
    y_out   = bit_out ? s[MF+1:1] : s[MF:0];
  end
endmodule

// File: rtl/base_scale.sv
module base_scale #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic [W-1:0]  val,
  input  logic [CW-1:0] k,
  output logic [W-1:0]  res
);
  logic signed [W+CW:0] prod;

  always_comb begin
    prod = $signed(val) * $signed({1'b0, k});
    res  = W'(prod >>> CW);
  end
endmodule

// File: rtl/log_unit.sv
module log_unit
  import log_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_op,
  input  logic [INT_W+FRAC_W-1:0]   in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [INT_W+FRAC_W-1:0]   out_data,
  output logic                      out_err,
  output logic                      done
);
  localparam int  NBITS = INT_W + FRAC_W;
  localparam int  MF    = FRAC_W + 1;
  localparam int  PW    = $clog2(NBITS);
  localparam int  CW    = NBITS;
  localparam int  CNT_W = $clog2(FRAC_W + 1);
  localparam real CSCL  = 2.0 ** CW;
  localparam logic [CW-1:0]    K10     = CW'($rtoi(INV_LOG2_10 * CSCL));
  localparam logic [CW-1:0]    KE      = CW'($rtoi(INV_LOG2_E * CSCL));
  localparam logic [NBITS-1:0] MOST_NEG = {1'b1, {(NBITS-1){1'b0}}};
  localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(FRAC_W - 1);

  state_e             st_q;
  op_e                op_q;
  logic [MF:0]        y_q;
  logic [INT_W-1:0]   kint_q;
  logic [FRAC_W-1:0]  frac_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [NBITS-1:0]   res_q;
  logic               err_q;
  logic               done_q;

  logic [PW-1:0]      lead_pos;
  logic [MF:0]        mant_w;
  logic               fbit_w;
  logic [MF:0]        y_next;
  logic [FRAC_W-1:0]  frac_next;
  logic [NBITS-1:0]   log2_full;
  logic [CW-1:0]      kconst;
  logic [NBITS-1:0]   scaled_w;
  logic [INT_W-1:0]   kint_w;
  logic               bad_in;

  lead_one_find #(.W(NBITS), .PW(PW)) u_lead (
    .vec (in_data),
    .pos (lead_pos)
  );

  mant_align #(.W(NBITS), .MF(MF), .PW(PW)) u_align (
    .vec  (in_data),
    .pos  (lead_pos),
    .mant (mant_w)
  );

  sq_step #(.MF(MF)) u_step (
    .y_in    (y_q),
    .bit_out (fbit_w),
    .y_out   (y_next)
  );

  base_scale #(.W(NBITS), .CW(CW)) u_scale (
    .val (res_q),
    .k   (kconst),
    .res (scaled_w)
  );

  always_comb begin
    kint_w    = INT_W'(lead_pos) - INT_W'(FRAC_W);
    frac_next = {frac_q[FRAC_W-2:0], fbit_w};
    log2_full = {kint_q, frac_next};
    kconst    = (op_q == OP_LN) ? KE : K10;
    bad_in    = (in_data == '0) || (op_e'(in_op) == OP_ROOT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_LOG2;
      y_q    <= '0;
      kint_q <= '0;
      frac_q <= '0;
      cnt_q  <= '0;
      res_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            op_q <= op_e'(in_op);
            if (bad_in) begin
              res_q  <= MOST_NEG;
              err_q  <= 1'b1;
              done_q <= 1'b1;
              st_q   <= ST_HOLD;
            end else begin
              y_q    <= mant_w;
              kint_q <= kint_w;
              frac_q <= '0;
              cnt_q  <= '0;
              err_q  <= 1'b0;
              st_q   <= ST_ITER;
            end
          end
        end
        ST_ITER: begin
          y_q    <= y_next;
          frac_q <= frac_next;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == LAST_IT) begin
            res_q <= log2_full;
            if (op_q == OP_LOG2) begin
              done_q <= 1'b1;
              st_q   <= ST_HOLD;
            end else begin
              st_q   <= ST_SCALE;
            end
          end
        end
        ST_SCALE: begin
          res_q  <= scaled_w;
          done_q <= 1'b1;
          st_q   <= ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_HOLD);
  assign out_data  = res_q;
  assign out_err   = err_q;
  assign done      = done_q;

endmodule

// File: rtl/log_unit_chk.sv
module log_unit_chk #(
  parameter int NBITS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_op,
  input logic [NBITS-1:0] in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NBITS-1:0] out_data,
  input logic             out_err,
  input logic             done
);
  localparam logic [NBITS-1:0] MOST_NEG = {1'b1, {(NBITS-1){1'b0}}};

  assert_busy_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data == '0) |=> (out_valid && out_err && out_data == MOST_NEG));

  assert_reserved_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'b00) |=> (out_valid && out_err && out_data == MOST_NEG));

  assert_no_early_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data != '0 && in_op != 2'b00) |=> !out_valid);

  assert_done_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  assert_good_no_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data != '0 && in_op != 2'b00) |=> !out_err);

endmodule

bind log_unit log_unit_chk #(.NBITS(INT_W + FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_err   (out_err),
  .done      (done)
);

// File: tb/sim_log_unit.sv
`timescale 1ns/1ps
module sim_log_unit;
  localparam int INT_W  = 8;
  localparam int FRAC_W = 8;
  localparam int NB     = INT_W + FRAC_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_op = 2'b01;
  logic [NB-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [NB-1:0] out_data;
  logic          out_err;
  logic          done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  log_unit #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_err(out_err), .done(done)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] din;
    logic [15:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 17;
  // Expected values worked out from R4..R9 with K10=19728, KE=45426.
  localparam vec_t VECS [NV] = '{
    '{2'b01, 16'h0100, 16'h0000, 1'b0},  // R4 log2(1)
    '{2'b01, 16'h0400, 16'h0200, 1'b0},  // R4 log2(4)
    '{2'b01, 16'h0080, 16'hFF00, 1'b0},  // R4 log2(0.5)
    '{2'b01, 16'h0001, 16'hF800, 1'b0},  // R4 smallest operand
    '{2'b01, 16'h8000, 16'h0700, 1'b0},  // R4 top bit
    '{2'b01, 16'h0300, 16'h0195, 1'b0},  // R5 log2(3)
    '{2'b01, 16'h0180, 16'h0095, 1'b0},  // R5 log2(1.5)
    '{2'b01, 16'h0003, 16'hF995, 1'b0},  // R5 log2(3/256)
    '{2'b10, 16'h0200, 16'h004D, 1'b0},  // R6 log10(2)
    '{2'b10, 16'h0400, 16'h009A, 1'b0},  // R6 log10(4)
    '{2'b10, 16'h0300, 16'h0079, 1'b0},  // R6 log10(3)
    '{2'b11, 16'h0200, 16'h00B1, 1'b0},  // R7 ln(2)
    '{2'b11, 16'h0080, 16'hFF4E, 1'b0},  // R7 ln(0.5), floor
    '{2'b11, 16'h0300, 16'h0118, 1'b0},  // R7 ln(3)
    '{2'b11, 16'h0003, 16'hFB8D, 1'b0},  // R7 ln(3/256)
    '{2'b01, 16'h0000, 16'h8000, 1'b1},  // R8 zero
    '{2'b00, 16'h0300, 16'h8000, 1'b1}   // R9 reserved code
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Launch one operand; returns result, latency in edges, and done seen on first valid cycle.
  task automatic launch(input logic [1:0] op, input logic [NB-1:0] din,
                        output logic [NB-1:0] res, output logic err,
                        output int lat, output logic dn);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_data = din; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    res = out_data; err = out_err; dn = done;
  endtask

  task automatic release_out();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] r;
    logic e, d;
    int lat;
    int exp_lat;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1,  "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(done == 1'b0,      "R1 done", done, 0);
    check(out_err == 1'b0,   "R1 out_err", out_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      launch(VECS[i].op, VECS[i].din, r, e, lat, d);
      exp_lat = VECS[i].err ? 0 : ((VECS[i].op == 2'b01) ? FRAC_W : FRAC_W + 1);
      check(r == VECS[i].exp, $sformatf("R4-R9 data vec%0d", i), r, VECS[i].exp);
      check(e == VECS[i].err, $sformatf("R8 R9 R12 err vec%0d", i), e, VECS[i].err);
      check(lat == exp_lat,   $sformatf("R10 latency vec%0d", i), lat, exp_lat);
      check(d == 1'b1,        $sformatf("R11 done vec%0d", i), d, 1);
      release_out();
      check(out_valid == 1'b0 && in_ready == 1'b1, "R3 release", {out_valid, in_ready}, 2'b01);
    end

    // R2: input offered while busy is ignored
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b01; in_data = 16'h0400;
    @(posedge clk);
    @(negedge clk);
    in_data = 16'h0000; in_op = 2'b00;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R2 busy in_ready", in_ready, 0);
    while (!out_valid) @(negedge clk);
    in_valid = 1'b0;
    check(out_data == 16'h0200, "R2 busy input ignored data", out_data, 16'h0200);
    check(out_err == 1'b0, "R2 busy input ignored err", out_err, 0);

    // R3 back-pressure with R11 single pulse
    r = out_data;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R3 valid held", out_valid, 1);
      check(out_data == r, "R3 data stable", out_data, r);
      check(done == 1'b0, "R11 done single", done, 0);
      check(in_ready == 1'b0, "R2 ready low while holding", in_ready, 0);
    end
    release_out();
    check(out_valid == 1'b0 && in_ready == 1'b1, "R3 release after hold", {out_valid, in_ready}, 2'b01);

    // R9 reserved code with zero operand too; R8 zero on log10
    launch(2'b00, 16'h0000, r, e, lat, d);
    check(r == 16'h8000 && e == 1'b1, "R9 reserved zero", {e, r}, {1'b1, 16'h8000});
    release_out();
    launch(2'b10, 16'h0000, r, e, lat, d);
    check(r == 16'h8000 && e == 1'b1, "R8 zero log10", {e, r}, {1'b1, 16'h8000});
    check(lat == 0, "R10 error latency", lat, 0);
    release_out();

    // R12 after an error result, a good result has err low
    launch(2'b11, 16'h0100, r, e, lat, d);
    check(e == 1'b0 && r == 16'h0000, "R12 err cleared ln(1)", {e, r}, 0);
    release_out();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule